// File: doc/BRIEF.md
# ADC Step Sequencer Controller

This block runs a short programmed list of conversion steps against an external analog-to-digital converter without help from a processor. Each step holds a 5-bit input channel, a differential/single-ended mode bit, an interrupt-enable bit and an end-of-list bit. A one-cycle trigger starts a pass over the list. For each step the block requests one conversion and waits for the converter to answer. It then stores the 12-bit result in a result FIFO of 32-bit words and moves straight on to the next step.

The pass stops after the first step whose end-of-list bit is set. If no step sets that bit, the pass stops after the last implemented step. The parameter `STEPS` sets the list length and the FIFO depth together; the supported values are 8, 4 and 1. A consumer such as a DMA engine drains the FIFO through a show-ahead pop port. Overflow, underflow and missed triggers are recorded in sticky flags that only reset clears.

Top module: `seq_ctrl`

## Requirements
- R1: After reset the block is idle. `conv_start`, `irq`, `fifo_count` and all three sticky flags are 0, and `pop_data` is 0.
- R2: A `trig` pulse sampled while idle makes `busy` and `conv_start` high in the next cycle. In that cycle `conv_chan` and `conv_diff` carry the settings of step 0.
- R3: `conv_start` is high for exactly one cycle per step and is low whenever the block is idle. The next step's `conv_start` appears in the cycle after the edge that samples `conv_done` for the previous step, and carries that step's channel and mode.
- R4: A pass ends with the step whose end-of-list bit is set. `busy` is low in the cycle after the edge that samples that step's `conv_done`.
- R5: If no step has its end-of-list bit set, the pass ends after step `STEPS-1`.
- R6: Each FIFO word holds the conversion result in bits [11:0] and zeros in bits [31:12]. A full-scale code of 4095 is stored unchanged.
- R7: The FIFO holds up to `STEPS` words in conversion order. `pop_data` shows the oldest word, and a `pop` while non-empty removes it at the next edge. `fifo_count` never exceeds `STEPS`.
- R8: A result that arrives while `fifo_count` equals `STEPS` is discarded, even if a pop happens in the same cycle. It leaves the FIFO contents unchanged and sets `ovf_flag`, which stays set.
- R9: A `pop` while the FIFO is empty leaves `fifo_count` at 0 and sets `unf_flag`, which stays set. `pop_data` is 0 while the FIFO is empty.
- R10: A `trig` sampled while busy does not restart or change the running pass, and it sets `miss_flag`, which stays set.
- R11: `irq` is high for one cycle, the cycle after the edge that writes the result of a step whose interrupt-enable bit is set. It stays low for steps without that bit and for results that were discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write one step entry |
| cfg_idx | input | IDX_W | Step index to write |
| cfg_chan | input | 5 | Channel select for the step |
| cfg_diff | input | 1 | 1 = differential, 0 = single-ended |
| cfg_irq | input | 1 | Interrupt when this step's result is stored |
| cfg_last | input | 1 | This step ends the list |
| trig | input | 1 | One-cycle start pulse |
| conv_start | output | 1 | Conversion request pulse |
| conv_chan | output | 5 | Channel for the request |
| conv_diff | output | 1 | Mode for the request |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | 12 | Converter result, unsigned |
| pop | input | 1 | Remove the head FIFO word |
| pop_data | output | 32 | Head FIFO word, 0 when empty |
| fifo_count | output | CNT_W | Words held in the FIFO |
| busy | output | 1 | A pass is running |
| irq | output | 1 | Step-complete interrupt pulse |
| ovf_flag | output | 1 | Sticky: result discarded |
| unf_flag | output | 1 | Sticky: pop while empty |
| miss_flag | output | 1 | Sticky: trigger while busy |

## Verification
The request pulse is due one cycle after the edge that samples a trigger, or one cycle after the edge that samples the previous step's done strobe. `fifo_count`, `irq` and the sticky flags change one cycle after the edge that samples the strobe or the pop, and `pop_data` follows the FIFO state with no added delay. The bench's behavioural model applies exactly these delays at each rising edge, using the inputs as the design sees them. Every output is compared with the model at the following falling edge, so each result is checked in the cycle it is due. Converter latency is varied between 0 and 2 wait cycles so that both back-to-back and slower answers are covered.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int CHAN_W = 5;
    localparam int RES_W  = 12;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              diff;
        logic              irq_en;
        logic              last;
    } step_t;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_REQ  = 2'd1,
        W_WAIT = 2'd2
    } wstate_e;
endpackage

// File: rtl/seq_step_file.sv
module seq_step_file
    import seq_pkg::*;
#(
    parameter int STEPS = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  step_t            wr_step,
    input  logic [IDX_W-1:0] rd_idx,
    output step_t            rd_step
);
    step_t [STEPS-1:0] regs_d, regs_q;

    for (genvar g = 0; g < STEPS; g++) begin : g_entry
        assign regs_d[g] = (we && wr_idx == IDX_W'(g)) ? wr_step : regs_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rd_step = regs_q[rd_idx];
endmodule

// File: rtl/seq_result_fifo.sv
module seq_result_fifo
    import seq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [RES_W-1:0]  push_data,
    input  logic              pop,
    output logic              push_ok,
    output logic [WORD_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              ovf,
    output logic              unf
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             unf;
    } fifo_s;

    fifo_s            s_d, s_q;
    logic [RES_W-1:0] mem_q [DEPTH];
    logic             pop_ok;

    function automatic logic [IDX_W-1:0] step_ptr(input logic [IDX_W-1:0] p);
        return (p == TOP_IDX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        push_ok = push && (s_q.cnt != FULL_CNT);
        pop_ok  = pop && (s_q.cnt != '0);
        if (push && !push_ok) s_d.ovf = 1'b1;
        if (pop && !pop_ok)   s_d.unf = 1'b1;
        if (push_ok) s_d.wr = step_ptr(s_q.wr);
        if (pop_ok)  s_d.rd = step_ptr(s_q.rd);
        s_d.cnt = s_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[s_q.wr] <= push_data;
    end

    assign head  = (s_q.cnt != '0) ? {{(WORD_W-RES_W){1'b0}}, mem_q[s_q.rd]} : '0;
    assign count = s_q.cnt;
    assign ovf   = s_q.ovf;
    assign unf   = s_q.unf;
endmodule

// File: rtl/seq_walker.sv
module seq_walker
    import seq_pkg::*;
#(
    parameter int STEPS = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             conv_done,
    input  step_t            cur,
    input  logic             push_ok,
    output logic [IDX_W-1:0] idx,
    output logic             conv_start,
    output logic             busy,
    output logic             push,
    output logic             irq,
    output logic             miss
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);

    typedef struct packed {
        wstate_e          st;
        logic [IDX_W-1:0] idx;
        logic             irq;
        logic             miss;
    } walk_s;

    walk_s s_d, s_q;

    always_comb begin
        s_d     = s_q;
        push    = (s_q.st == W_WAIT) && conv_done;
        s_d.irq = push_ok && cur.irq_en;
        if (trig && s_q.st != W_IDLE) s_d.miss = 1'b1;
        unique case (s_q.st)
            W_IDLE: if (trig) begin
                s_d.st  = W_REQ;
                s_d.idx = '0;
            end
            W_REQ:  s_d.st = W_WAIT;
            W_WAIT: if (conv_done) begin
                if (cur.last || s_q.idx == LAST_IDX) begin
                    s_d.st = W_IDLE;
                end else begin
                    s_d.st  = W_REQ;
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            default: s_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: W_IDLE, idx: '0, irq: 1'b0, miss: 1'b0};
        else        s_q <= s_d;
    end

    assign idx        = s_q.idx;
    assign conv_start = (s_q.st == W_REQ);
    assign busy       = (s_q.st != W_IDLE);
    assign irq        = s_q.irq;
    assign miss       = s_q.miss;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int  STEPS = 8,
    localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1,
    localparam int CNT_W = $clog2(STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic              cfg_diff,
    input  logic              cfg_irq,
    input  logic              cfg_last,
    input  logic              trig,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              conv_diff,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    input  logic              pop,
    output logic [WORD_W-1:0] pop_data,
    output logic [CNT_W-1:0]  fifo_count,
    output logic              busy,
    output logic              irq,
    output logic              ovf_flag,
    output logic              unf_flag,
    output logic              miss_flag
);
    step_t            wr_step, cur_step;
    logic [IDX_W-1:0] cur_idx;
    logic             push, push_ok;

    assign wr_step = '{chan: cfg_chan, diff: cfg_diff, irq_en: cfg_irq, last: cfg_last};

    seq_step_file #(.STEPS(STEPS), .IDX_W(IDX_W)) u_steps (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_step (wr_step),
        .rd_idx  (cur_idx),
        .rd_step (cur_step)
    );

    seq_walker #(.STEPS(STEPS), .IDX_W(IDX_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .conv_done  (conv_done),
        .cur        (cur_step),
        .push_ok    (push_ok),
        .idx        (cur_idx),
        .conv_start (conv_start),
        .busy       (busy),
        .push       (push),
        .irq        (irq),
        .miss       (miss_flag)
    );

    seq_result_fifo #(.DEPTH(STEPS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (conv_data),
        .pop       (pop),
        .push_ok   (push_ok),
        .head      (pop_data),
        .count     (fifo_count),
        .ovf       (ovf_flag),
        .unf       (unf_flag)
    );

    assign conv_chan = conv_start ? cur_step.chan : '0;
    assign conv_diff = conv_start && cur_step.diff;
endmodule

// File: rtl/seq_ctrl_chk.sv
module seq_ctrl_chk #(
    parameter int  STEPS = 8,
    localparam int CNT_W = $clog2(STEPS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig,
    input logic             busy,
    input logic             conv_start,
    input logic             irq,
    input logic             pop,
    input logic [CNT_W-1:0] fifo_count,
    input logic             ovf_flag,
    input logic             unf_flag,
    input logic             miss_flag
);
    p_trig_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !busy) |=> (busy && conv_start));

    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !conv_start);

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(fifo_count) <= STEPS);

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && fifo_count == '0) |=> (unf_flag && fifo_count == '0));

    p_unf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |=> unf_flag);

    p_busy_trig_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && busy) |=> miss_flag);

    p_miss_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        miss_flag |=> miss_flag);

    p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

bind seq_ctrl seq_ctrl_chk #(.STEPS(STEPS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig),
    .busy       (busy),
    .conv_start (conv_start),
    .irq        (irq),
    .pop        (pop),
    .fifo_count (fifo_count),
    .ovf_flag   (ovf_flag),
    .unf_flag   (unf_flag),
    .miss_flag  (miss_flag)
);

// File: tb/sim_seq_ctrl.sv
module sim_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int STEPS      = 8;
    localparam int IDX_W      = 3;
    localparam int CNT_W      = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [IDX_W-1:0]  cfg_idx = '0;
    logic [4:0]        cfg_chan = '0;
    logic              cfg_diff = 1'b0, cfg_irq = 1'b0, cfg_last = 1'b0;
    logic              trig = 1'b0;
    logic              conv_start;
    logic [4:0]        conv_chan;
    logic              conv_diff;
    logic              conv_done = 1'b0;
    logic [11:0]       conv_data = '0;
    logic              pop = 1'b0;
    logic [31:0]       pop_data;
    logic [CNT_W-1:0]  fifo_count;
    logic              busy, irq, ovf_flag, unf_flag, miss_flag;

    seq_ctrl #(.STEPS(STEPS)) u0 (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // reference model, updated at rising edges
    logic [4:0]  e_chan [STEPS];
    bit          e_diff [STEPS];
    bit          e_irq  [STEPS];
    bit          e_last [STEPS];
    logic [11:0] m_q [$];
    int          m_st = 0;
    int          m_idx = 0;
    bit          m_irq = 0, m_ovf = 0, m_unf = 0, m_miss = 0;
    bit          m_live = 0;

    always @(posedge clk) begin
        int sz;
        bit do_push, acc;
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            finish_run();
        end
        if (!rst_n) begin
            m_q.delete();
            m_st = 0; m_idx = 0;
            m_irq = 0; m_ovf = 0; m_unf = 0; m_miss = 0;
            for (int i = 0; i < STEPS; i++) begin
                e_chan[i] = '0; e_diff[i] = 0; e_irq[i] = 0; e_last[i] = 0;
            end
        end else begin
            m_live  = 1;
            sz      = m_q.size();
            do_push = (m_st == 2) && conv_done;
            acc     = do_push && (sz < STEPS);
            m_irq   = acc && e_irq[m_idx];
            if (do_push && !acc) m_ovf = 1;
            if (pop) begin
                if (sz == 0) m_unf = 1;
                else void'(m_q.pop_front());
            end
            if (acc) m_q.push_back(conv_data);
            if (trig && m_st != 0) m_miss = 1;
            case (m_st)
                0: if (trig) begin m_st = 1; m_idx = 0; end
                1: m_st = 2;
                default: if (conv_done) begin
                    if (e_last[m_idx] || m_idx == STEPS - 1) m_st = 0;
                    else begin m_idx++; m_st = 1; end
                end
            endcase
            if (cfg_we) begin
                e_chan[cfg_idx] = cfg_chan; e_diff[cfg_idx] = cfg_diff;
                e_irq[cfg_idx]  = cfg_irq;  e_last[cfg_idx] = cfg_last;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && m_live) begin
            chk("R3 conv_start", 32'(conv_start), 32'(m_st == 1));
            if (m_st == 1) begin
                chk("R2/R3 conv_chan", 32'(conv_chan), 32'(e_chan[m_idx]));
                chk("R2/R3 conv_diff", 32'(conv_diff), 32'(e_diff[m_idx]));
            end
            chk("R4 busy", 32'(busy), 32'(m_st != 0));
            chk("R11 irq", 32'(irq), 32'(m_irq));
            chk("R7 fifo_count", 32'(fifo_count), 32'(m_q.size()));
            chk("R6 pop_data", pop_data, (m_q.size() > 0) ? {20'd0, m_q[0]} : 32'd0);
            chk("R8 ovf_flag", 32'(ovf_flag), 32'(m_ovf));
            chk("R9 unf_flag", 32'(unf_flag), 32'(m_unf));
            chk("R10 miss_flag", 32'(miss_flag), 32'(m_miss));
        end
    end

    // converter model with adjustable latency
    int lat = 0;
    int pend = 0;
    int seed = 4095;
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (conv_start) pend = lat + 1;
        else if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                conv_done = 1'b1;
                conv_data = 12'(seed);
                seed      = seed + 517;
            end
        end
    end

    task automatic program_step(input int i, input int ch, input bit d, input bit q, input bit l);
        cfg_we = 1'b1; cfg_idx = IDX_W'(i); cfg_chan = 5'(ch);
        cfg_diff = d; cfg_irq = q; cfg_last = l;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_trig();
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic pop_n(input int n);
        pop = 1'b1;
        repeat (n) @(negedge clk);
        pop = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 conv_start", 32'(conv_start), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 fifo_count", 32'(fifo_count), 0);
        chk("R1 flags", {29'd0, ovf_flag, unf_flag, miss_flag}, 0);
        chk("R1 pop_data", pop_data, 0);

        // R4: list ends at step 3; back-to-back answers; first result full scale (R6)
        for (int i = 0; i < STEPS; i++)
            program_step(i, 2 * i + 1, i[0], (i == 1) || (i == 3), i == 3);
        lat = 0;
        pulse_trig();
        wait_idle();
        chk("R4 results after end flag", 32'(fifo_count), 4);
        chk("R6 full scale word", pop_data, 32'd4095);
        pop_n(4);
        chk("R7 drained", 32'(fifo_count), 0);

        // R5: no end flag, all steps run; R10: trigger while busy
        for (int i = 0; i < STEPS; i++)
            program_step(i, 19 - i, !i[0], i == STEPS - 1, 1'b0);
        lat = 2;
        pulse_trig();
        repeat (3) @(negedge clk);
        pulse_trig();
        wait_idle();
        chk("R5 full list run", 32'(fifo_count), STEPS);
        chk("R10 miss flag", 32'(miss_flag), 1);

        // R8: FIFO full, results discarded
        program_step(1, 7, 1'b1, 1'b1, 1'b1);
        lat = 1;
        pulse_trig();
        wait_idle();
        chk("R8 count held", 32'(fifo_count), STEPS);
        chk("R8 ovf flag", 32'(ovf_flag), 1);

        // R9: drain then pop once more while empty
        pop_n(STEPS + 1);
        @(negedge clk);
        chk("R9 empty count", 32'(fifo_count), 0);
        chk("R9 unf flag", 32'(unf_flag), 1);
        chk("R9 empty data", pop_data, 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule